// File: doc/BRIEF.md
# Two-wire Bus Port Expander

This block is a slave on a two-wire serial bus (SCL clock, SDA data). It controls eight bidirectional port pins. A bus master uses write transactions to configure the port and read transactions to sample it. The bus lines are oversampled by the local clock `clk`. SDA is open drain, so the block never drives it high. It only asserts `sda_oe`, and the pad pulls the line low while `sda_oe` is 1.

Each pin has its own direction bit. A write transaction carries two kinds of data byte. The first byte after the address sets which pins are outputs. The following bytes set the levels those outputs drive. A read transaction returns the synchronised pin levels. Each byte is captured on a clock of the acknowledge phase, so a master that keeps acknowledging receives a fresh snapshot each time.

The port and strap pins are plain level signals. The bus runs at the master's pace with no back-pressure: the block never stretches SCL, and the master does not wait on a ready signal. The slave address is a 4-bit prefix set by a parameter, followed by three strap inputs, so several expanders can share one bus.

Top module: `i2c_port_expander`

## Requirements
- R1: After reset, every pin is an input (`port_oe` = 0), `port_out` = 0, and SDA is released.
- R2: A START (SDA falls while SCL is high) begins address reception from any state, including a repeated START inside a transaction. A STOP (SDA rises while SCL is high) returns the block to idle.
- R3: The first byte after START is sent MSB first. Its upper 7 bits are the 4-bit prefix followed by the 3 strap bits, and its last bit is the transfer direction (0 = write, 1 = read). On a match, the block pulls SDA low during the ninth clock.
- R4: If the address does not match, the block does not acknowledge and changes no register. Every following byte is ignored until the next START.
- R5: In a write, the first data byte loads the direction register (bit value 1 = output) and is acknowledged on the ninth clock.
- R6: The second data byte loads the output register. Every further data byte in the same write also loads the output register and is acknowledged.
- R7: `port_oe` equals the direction register and `port_out` equals the output register. Both hold their values across later transactions, including reads, until a write changes them.
- R8: In a read, the pin levels (after a two-flop synchroniser) are captured on the rising SCL edge of the address acknowledge clock. They are shifted out MSB first, with SDA changing only while SCL is low.
- R9: After each read byte, if the master acknowledges (SDA low on the ninth clock), the next byte is a new capture taken on that clock. If the master does not acknowledge, SDA stays released until the next START or STOP.
- R10: A STOP or START that arrives before all 8 bits of a data byte abandons that byte, and no register is updated.
- R11: With `STRAP_REVERSE` = 1, the strap bits enter the address in reversed order: address bits 3..1 are cs_strap[0], cs_strap[1], cs_strap[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cs_strap | input | 3 | Address strap inputs |
| port_in | input | 8 | Pin levels seen at the pads |
| port_out | output | 8 | Levels driven on output pins |
| port_oe | output | 8 | Per-pin output enable (1 = output) |

## Verification
The bench sets the prefix to 4'b1011 instead of the default. It also sets `STRAP_REVERSE` = 1 and ties the straps to a pattern that is not symmetric. With these values, an address built with the wrong strap order or a wrong prefix bit fails to match, and the bench sees the missing acknowledge. Changing the straps at run time shows that the compare tracks the live strap inputs. Because `SYNC_STAGES` is 2, pin changes made during the acknowledge clock are still captured well before the sampling edge, so each fresh read capture can be checked exactly.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int BYTE_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int PREFIX_W = 4;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_HOLD
  } eng_state_t;
endpackage

// File: rtl/iox_sync.sv
module iox_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= RST_VAL;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= RST_VAL;
        else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/iox_line_events.sv
module iox_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // data edges while the clock stays high mark bus conditions
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/iox_bus_engine.sv
module iox_bus_engine
  import iox_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX   = 4'b0100,
  parameter bit                  STRAP_REVERSE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0]  in_latch,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               ld_dir,
  output logic               ld_out,
  output logic               ld_in,
  output logic               sda_oe
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [STRAP_W-1:0] strap_ord;
  if (STRAP_REVERSE) begin : g_rev
    for (genvar i = 0; i < STRAP_W; i++) begin : g_bit
      assign strap_ord[i] = strap[STRAP_W-1-i];
    end
  end else begin : g_fwd
    assign strap_ord = strap;
  end

  logic [BYTE_W-2:0] my_addr;
  assign my_addr = {ADDR_PREFIX, strap_ord};

  eng_state_t       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic             rw_q, idx_q, mack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      idx_q   <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise && bit_cnt < FULL) begin
            rx_q    <= {rx_q[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == FULL) begin
            if (state == ST_ADDR) begin
              if (rx_q[BYTE_W-1:1] == my_addr) begin
                sda_oe <= 1'b1;
                rw_q   <= rx_q[0];
                idx_q  <= 1'b0;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end else begin
              sda_oe <= 1'b1;
              idx_q  <= 1'b1;
              state  <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              tx_q   <= in_latch;
              sda_oe <= ~in_latch[BYTE_W-1];
              state  <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise && bit_cnt < FULL) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == FULL) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              bit_cnt <= '0;
              tx_q    <= in_latch;
              sda_oe  <= ~in_latch[BYTE_W-1];
              state   <= ST_RD;
            end else begin
              state   <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  logic byte_done_wr;
  assign byte_done_wr = (state == ST_WR) && scl_fall && (bit_cnt == FULL);
  assign ld_dir  = byte_done_wr && !idx_q;
  assign ld_out  = byte_done_wr && idx_q;
  assign ld_in   = scl_rise && ((state == ST_ADDR_ACK && rw_q) ||
                                (state == ST_RD_ACK && !sda_s));
  assign rx_byte = rx_q;

  // slave only starts pulling SDA while the clock is low
  assert_ack_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // a START rearms the bit counter and frees the line
  assert_start_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bit_cnt == '0 && !sda_oe));
  // register loads only at the falling clock that closes a whole byte
  assert_write_strobe_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_dir || ld_out) |-> (scl_fall && !rw_q));
  // pin capture happens only in a read transaction
  assert_capture_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_in |-> rw_q);
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import iox_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX   = 4'b0100,
  parameter bit                  STRAP_REVERSE = 1'b0,
  parameter int                  SYNC_STAGES   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] cs_strap,
  input  logic [BYTE_W-1:0]  port_in,
  output logic [BYTE_W-1:0]  port_out,
  output logic [BYTE_W-1:0]  port_oe
);
  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] pin_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic ld_dir, ld_out, ld_in;
  logic [BYTE_W-1:0] rx_byte, dir_q, out_q, in_q;

  iox_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  iox_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(port_in), .q(pin_s));

  iox_line_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  iox_bus_engine #(.ADDR_PREFIX(ADDR_PREFIX), .STRAP_REVERSE(STRAP_REVERSE)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(cs_strap), .in_latch(in_q), .rx_byte(rx_byte),
    .ld_dir(ld_dir), .ld_out(ld_out), .ld_in(ld_in), .sda_oe(sda_oe));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      in_q  <= '0;
    end else begin
      if (ld_dir) dir_q <= rx_byte;
      if (ld_out) out_q <= rx_byte;
      if (ld_in)  in_q  <= pin_s;
    end

  assign port_oe  = dir_q;
  assign port_out = out_q;

  assert_reset_input_R1: assert property (@(posedge clk)
    !rst_n |=> (port_oe == '0));
  assert_dir_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_dir |=> $stable(port_oe));
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_out |=> $stable(port_out));
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_dir, ld_out, ld_in}));
endmodule

// File: tb/tb_i2c_port_expander.sv
module tb_i2c_port_expander;
  localparam logic [3:0] PFX = 4'b1011;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] cs = 3'b110;
  logic [7:0] pin = 8'h00;
  logic sda_oe;
  logic [7:0] p_out, p_oe;
  wire sda_line = m_sda & ~sda_oe;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_port_expander #(.ADDR_PREFIX(PFX), .STRAP_REVERSE(1'b1), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cs_strap(cs), .port_in(pin), .port_out(p_out), .port_oe(p_oe));

  function automatic logic [6:0] exp_addr(input logic [2:0] s);
    return {PFX, s[0], s[1], s[2]};  // reversed strap order (R11)
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask
  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask
  task automatic wbit(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask
  task automatic rbit(output logic b);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q/2); b = sda_line; wq(Q - Q/2); m_scl = 1'b0; wq(Q);
  endtask
  task automatic send(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a); ack = ~a;
  endtask
  task automatic recv(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
  endtask

  task automatic do_write(input logic [7:0] d, input logic [7:0] o, input string tag);
    logic a;
    bus_start;
    send({exp_addr(cs), 1'b0}, a); chk({tag, " R3 addr ack"}, a, 1);
    send(d, a); chk({tag, " R5 dir ack"}, a, 1);
    send(o, a); chk({tag, " R6 out ack"}, a, 1);
    bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v, d, o, pv;
    void'($urandom(32'h5eed_1234));
    wq(5); rst_n = 1'b1; wq(5);
    chk("R1 port_oe reset", p_oe, 8'h00);
    chk("R1 port_out reset", p_out, 8'h00);
    chk("R1 sda released", sda_oe, 0);

    do_write(8'hA5, 8'h3C, "basic");
    chk("R7 port_oe", p_oe, 8'hA5);
    chk("R7 port_out", p_out, 8'h3C);

    // extra data bytes keep overwriting the output register
    bus_start;
    send({exp_addr(cs), 1'b0}, a);
    send(8'h0F, a); send(8'h11, a); send(8'h22, a); chk("R6 third byte ack", a, 1);
    bus_stop;
    chk("R6 last byte wins", p_out, 8'h22);
    chk("R5 dir second", p_oe, 8'h0F);

    // wrong address: no ack, bytes ignored
    bus_start;
    send({exp_addr(cs) ^ 7'h01, 1'b0}, a); chk("R4 no addr ack", a, 0);
    send(8'hFF, a); chk("R4 no data ack", a, 0);
    send(8'hFF, a);
    bus_stop;
    chk("R4 dir untouched", p_oe, 8'h0F);
    chk("R4 out untouched", p_out, 8'h22);

    // live strap change
    cs = 3'b011;
    bus_start; send({exp_addr(3'b110), 1'b0}, a); chk("R11 old straps rejected", a, 0); bus_stop;
    bus_start; send({exp_addr(cs), 1'b0}, a); chk("R11 new straps accepted", a, 1);
    send(8'h81, a); bus_stop;
    chk("R11 dir via new straps", p_oe, 8'h81);
    cs = 3'b110;

    // single read with NACK, then released line
    pin = 8'h9A;
    bus_start; send({exp_addr(cs), 1'b1}, a); chk("R3 read addr ack", a, 1);
    recv(v); chk("R8 read byte", v, 8'h9A);
    pin = 8'h00;
    wbit(1'b1);
    recv(v); chk("R9 released after nack", v, 8'hFF);
    bus_stop;
    chk("R7 dir kept over read", p_oe, 8'h81);

    // multi-byte read with fresh capture per ack
    pin = 8'h5C;
    bus_start; send({exp_addr(cs), 1'b1}, a);
    recv(v); chk("R9 first capture", v, 8'h5C);
    pin = 8'hE1; wbit(1'b0);
    recv(v); chk("R9 fresh capture", v, 8'hE1);
    pin = 8'h07; wbit(1'b0);
    recv(v); chk("R9 third capture", v, 8'h07);
    wbit(1'b1); bus_stop;

    // stop mid-byte abandons the output byte
    bus_start; send({exp_addr(cs), 1'b0}, a);
    send(8'hF0, a);
    for (int i = 0; i < 5; i++) wbit(1'b1);
    bus_stop;
    chk("R10 dir loaded", p_oe, 8'hF0);
    chk("R10 out abandoned on stop", p_out, 8'h22);

    // repeated start mid-byte abandons the direction byte, then read
    pin = 8'h6B;
    bus_start; send({exp_addr(cs), 1'b0}, a);
    for (int i = 0; i < 3; i++) wbit(1'b0);
    bus_start; send({exp_addr(cs), 1'b1}, a); chk("R2 repeated start ack", a, 1);
    recv(v); chk("R2 read after restart", v, 8'h6B);
    wbit(1'b1); bus_stop;
    chk("R10 dir abandoned on restart", p_oe, 8'hF0);

    for (int it = 0; it < 14; it++) begin
      int n;
      d = 8'($urandom); o = 8'($urandom);
      do_write(d, o, "rand");
      chk("R7 rand oe", p_oe, d);
      chk("R7 rand out", p_out, o);
      n = 1 + int'($urandom % 3);
      pv = 8'($urandom); pin = pv;
      bus_start; send({exp_addr(cs), 1'b1}, a); chk("R8 rand read ack", a, 1);
      for (int k = 0; k < n; k++) begin
        recv(v); chk("R8 rand read", v, pv);
        pv = 8'($urandom); pin = pv;
        wbit(k == n - 1);
      end
      bus_stop;
      chk("R7 rand hold oe", p_oe, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule